// File: doc/BRIEF.md
# DDR Traffic Monitor Counter Unit

This block sits next to a DDR controller and watches the command stream on the controller's PHY-side interface. For each channel it keeps four free-running 32-bit tallies: read commands, write commands, all accesses, and elapsed DDR clock cycles. Software reads these tallies over a simple 32-bit register bus to estimate memory bandwidth. It takes the difference between two samples modulo the counter range.

A control register decides when counting runs. Writes to it are bit-masked: the upper half-word of the write data says which of the lower bits may change. Counting requires the software enable to be set and exactly one memory-type bit to be set. When the software enable rises, all four tallies of that channel restart from zero. A parameter chooses between one control register per channel and a single control register shared by every channel. A read-only version word sits at the bottom of the map.

Top module: `ddr_traffic_mon`

## Requirements
- R1: Offset 0x00 reads the constant VERSION parameter; writes to it have no effect.
- R2: A write to a control register changes control bit n (n = 0..8) only when write-data bit n+16 is 1. The control bits are: bit 0 timer enable, bit 1 software enable, bit 2 LPDDR2/3 type, bit 3 hardware enable, bit 4 LPDDR4 type, bit 5 DDR4 type, bit 6 LPDDR5 type, and bits 8:7 LPDDR5 bank mode. Bits 31:9 read as zero.
- R3: Channel c has its control register at c*STRIDE+0x04, unless the shared option is set, in which case there is one control register at 0x04. Its counters are at c*STRIDE+0x20 (writes), +0x24 (reads), +0x28 (cycles) and +0x2C (accesses). All four counters read zero after reset.
- R4: The cycle counter increments on every clock edge at which the software enable is 1 and exactly one type bit (bits 2, 4, 5, 6) is 1. The edge that restarts the counters is the one exception.
- R5: While counting, each read strobe adds one to the read counter and each write strobe adds one to the write counter. The access counter adds both, so a read and a write in the same cycle add two, and the access counter always equals read plus write.
- R6: At the first clock edge after the software enable goes from 0 to 1, all four counters of that channel load zero.
- R7: While the software enable is 0, the counters hold their values and stay readable.
- R8: While more than one type bit (or none) is set, the counters hold. Counting resumes without a restart once exactly one type bit is set again.
- R9: Counters are CNT_W bits wide, wrap modulo 2^CNT_W without saturating, and read zero-extended.
- R10: Reads of unmapped offsets return zero. Writes to counter, version or unmapped offsets change nothing.
- R11: Read data and the read-valid flag appear one clock after the read request. Read-valid is low in every other cycle.
- R12: With per-channel control, enabling one channel leaves the counters of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DDR-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write request |
| reg_wdata | input | 32 | Write data; upper half-word is the bit mask |
| reg_re | input | 1 | Read request |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | High for one cycle when reg_rdata is new |
| cmd_rd | input | NUM_CH | Per-channel read command strobe |
| cmd_wr | input | NUM_CH | Per-channel write command strobe |

## Verification
Channel 0 is driven with interleaved read and write strobes that sometimes coincide. This separates a correct access sum from one that counts a coincident pair once. Channel 1 is strobed the whole time while its own enable is off, which shows that each channel's control stays separate. The control register is written with a mask that covers only some of the data bits, with a mask of zero, and with set bits above the field. Each of these shows a different masking fault. The cycle count is read both at the exact edge after a restart and across an illegal-type window, so a restart that comes one edge late and a freeze that fails to hold both give wrong values. A 300-cycle write burst on 8-bit counters checks wrap-around against saturation.

// File: rtl/ddrmon_pkg.sv
package ddrmon_pkg;

   localparam int CTRL_W = 9;

   localparam int B_TMR_EN = 0;
   localparam int B_SW_EN  = 1;
   localparam int B_T_L23  = 2;
   localparam int B_HW_EN  = 3;
   localparam int B_T_L4   = 4;
   localparam int B_T_D4   = 5;
   localparam int B_T_L5   = 6;
   localparam int B_BANK   = 7;

   localparam int OFS_VER  = 'h00;
   localparam int OFS_CTRL = 'h04;
   localparam int OFS_WR   = 'h20;
   localparam int OFS_ACC  = 'h2C;

   localparam logic [CTRL_W-1:0] TYPE_MASK =
      CTRL_W'((1 << B_T_L23) | (1 << B_T_L4) | (1 << B_T_D4) | (1 << B_T_L5));

   // counter order follows the address order within a channel window
   typedef enum logic [1:0] {
      SEL_WR  = 2'd0,
      SEL_RD  = 2'd1,
      SEL_CYC = 2'd2,
      SEL_ACC = 2'd3
   } cnt_sel_e;

   function automatic logic type_legal(input logic [CTRL_W-1:0] c);
      return $countones(c & TYPE_MASK) == 1;
   endfunction

endpackage

// File: rtl/ddrmon_ctrl_reg.sv
module ddrmon_ctrl_reg #(
   parameter int CTRL_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_bits,
   input  logic [CTRL_W-1:0] wr_mask,
   output logic [CTRL_W-1:0] ctrl_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         ctrl_q <= (ctrl_q & ~wr_mask) | (wr_bits & wr_mask);
      end
   end

endmodule

// File: rtl/ddrmon_counter.sv
module ddrmon_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         run,
   input  logic [1:0]   add,
   output logic [W-1:0] cnt_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= cnt_q + W'(add);
      end
   end

endmodule

// File: rtl/ddrmon_channel.sv
module ddrmon_channel
   import ddrmon_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sw_en,
   input  logic                  type_ok,
   input  logic                  cmd_rd,
   input  logic                  cmd_wr,
   output logic [3:0][CNT_W-1:0] cnt
);

   logic       sw_en_q;
   logic       restart;
   logic       run;
   logic [3:0][1:0] add;

   always_ff @(posedge clk) begin
      if (!rst_n) sw_en_q <= 1'b0;
      else        sw_en_q <= sw_en;
   end

   assign restart = sw_en & ~sw_en_q;
   assign run     = sw_en & type_ok & ~restart;

   assign add[SEL_WR]  = {1'b0, cmd_wr};
   assign add[SEL_RD]  = {1'b0, cmd_rd};
   assign add[SEL_CYC] = 2'd1;
   assign add[SEL_ACC] = 2'({1'b0, cmd_rd}) + 2'({1'b0, cmd_wr});

   for (genvar k = 0; k < 4; k++) begin : g_cnt
      ddrmon_counter #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (restart),
         .run   (run),
         .add   (add[k]),
         .cnt_q (cnt[k])
      );
   end

endmodule

// File: rtl/ddrmon_addr_dec.sv
module ddrmon_addr_dec
   import ddrmon_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NUM_CH = 2,
   parameter int NCTRL  = 2,
   parameter int STRIDE = 64
) (
   input  logic [ADDR_W-1:0] reg_addr,
   output logic              ver_hit,
   output logic [NCTRL-1:0]  ctrl_hit,
   output logic [NUM_CH-1:0] cnt_hit,
   output cnt_sel_e          cnt_sel
);

   int addr_i;
   assign addr_i = int'(reg_addr);

   always_comb begin
      ver_hit  = (addr_i == OFS_VER);
      ctrl_hit = '0;
      cnt_hit  = '0;
      cnt_sel  = SEL_WR;
      for (int k = 0; k < NCTRL; k++) begin
         if (addr_i == k * STRIDE + OFS_CTRL) ctrl_hit[k] = 1'b1;
      end
      for (int c = 0; c < NUM_CH; c++) begin
         if (addr_i >= c * STRIDE + OFS_WR && addr_i <= c * STRIDE + OFS_ACC &&
             reg_addr[1:0] == 2'b00) begin
            cnt_hit[c] = 1'b1;
            cnt_sel    = cnt_sel_e'(reg_addr[3:2]);
         end
      end
   end

endmodule

// File: rtl/ddr_traffic_mon.sv
module ddr_traffic_mon
   import ddrmon_pkg::*;
#(
   parameter int          NUM_CH      = 2,
   parameter int          CNT_W       = 32,
   parameter int          ADDR_W      = 8,
   parameter int          STRIDE      = 64,
   parameter bit          SHARED_CTRL = 1'b0,
   parameter logic [31:0] VERSION     = 32'h0000_0031
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_re,
   output logic [31:0]       reg_rdata,
   output logic              reg_rvalid,
   input  logic [NUM_CH-1:0] cmd_rd,
   input  logic [NUM_CH-1:0] cmd_wr
);

   localparam int NCTRL = SHARED_CTRL ? 1 : NUM_CH;

   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("NUM_CH must be 1..4");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_w
      $error("CNT_W must be 1..32");
   end
   if (STRIDE < 'h30 || (STRIDE % 16) != 0) begin : g_bad_stride
      $error("STRIDE must be a multiple of 16 and at least 0x30");
   end
   if (NUM_CH * STRIDE > (1 << ADDR_W)) begin : g_bad_aw
      $error("ADDR_W too narrow for NUM_CH windows");
   end

   logic [NCTRL-1:0][CTRL_W-1:0]  ctrl_q;
   logic [NUM_CH-1:0][3:0][CNT_W-1:0] cnt;
   logic [NUM_CH-1:0][CNT_W-1:0]  wr_cnt, rd_cnt, cyc_cnt, acc_cnt;

   logic              ver_hit;
   logic [NCTRL-1:0]  ctrl_hit;
   logic [NUM_CH-1:0] cnt_hit;
   cnt_sel_e          cnt_sel;
   logic [31:0]       rd_next;

   logic unused_wbits;
   assign unused_wbits = ^{reg_wdata[15:CTRL_W], reg_wdata[31:16+CTRL_W]};

   ddrmon_addr_dec #(
      .ADDR_W (ADDR_W),
      .NUM_CH (NUM_CH),
      .NCTRL  (NCTRL),
      .STRIDE (STRIDE)
   ) u_dec (
      .reg_addr (reg_addr),
      .ver_hit  (ver_hit),
      .ctrl_hit (ctrl_hit),
      .cnt_hit  (cnt_hit),
      .cnt_sel  (cnt_sel)
   );

   for (genvar k = 0; k < NCTRL; k++) begin : g_ctrl
      ddrmon_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_we & ctrl_hit[k]),
         .wr_bits (reg_wdata[CTRL_W-1:0]),
         .wr_mask (reg_wdata[16 +: CTRL_W]),
         .ctrl_q  (ctrl_q[k])
      );
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [CTRL_W-1:0] ch_ctrl;
      if (SHARED_CTRL) begin : g_sh
         assign ch_ctrl = ctrl_q[0];
      end else begin : g_own
         assign ch_ctrl = ctrl_q[c];
      end

      ddrmon_channel #(.CNT_W(CNT_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .sw_en   (ch_ctrl[B_SW_EN]),
         .type_ok (type_legal(ch_ctrl)),
         .cmd_rd  (cmd_rd[c]),
         .cmd_wr  (cmd_wr[c]),
         .cnt     (cnt[c])
      );

      assign wr_cnt[c]  = cnt[c][SEL_WR];
      assign rd_cnt[c]  = cnt[c][SEL_RD];
      assign cyc_cnt[c] = cnt[c][SEL_CYC];
      assign acc_cnt[c] = cnt[c][SEL_ACC];
   end

   always_comb begin
      rd_next = '0;
      if (ver_hit) rd_next = VERSION;
      for (int k = 0; k < NCTRL; k++) begin
         if (ctrl_hit[k]) rd_next = 32'(ctrl_q[k]);
      end
      for (int c = 0; c < NUM_CH; c++) begin
         if (cnt_hit[c]) rd_next = 32'(cnt[c][cnt_sel]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata  <= '0;
         reg_rvalid <= 1'b0;
      end else begin
         reg_rvalid <= reg_re;
         if (reg_re) reg_rdata <= rd_next;
      end
   end

endmodule

// File: rtl/ddr_traffic_mon_chk.sv
module ddr_traffic_mon_chk
   import ddrmon_pkg::*;
#(
   parameter int          ADDR_W  = 8,
   parameter int          CNT_W   = 32,
   parameter logic [31:0] VERSION = 32'h0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_we,
   input logic [31:0]       reg_wdata,
   input logic              reg_re,
   input logic [31:0]       reg_rdata,
   input logic              reg_rvalid,
   input logic [CTRL_W-1:0] ctrl0,
   input logic [CNT_W-1:0]  rd0,
   input logic [CNT_W-1:0]  wr0,
   input logic [CNT_W-1:0]  cyc0,
   input logic [CNT_W-1:0]  acc0
);

   logic ctrl_wr;
   logic legal0;
   assign ctrl_wr = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
   assign legal0  = $countones(ctrl0 & TYPE_MASK) == 1;

   // R11
   rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> reg_rvalid);
   // R11
   rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_re |=> !reg_rvalid);
   // R1
   version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_re && reg_addr == ADDR_W'(OFS_VER)) |=> reg_rdata == VERSION);
   // R2
   masked_bits_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> ((ctrl0 ^ $past(ctrl0)) & ~$past(reg_wdata[16 +: CTRL_W])) == '0);
   // R2
   ctrl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(ctrl0));
   // R6
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl0[B_SW_EN]) |=> (cyc0 == '0 && rd0 == '0 && wr0 == '0));
   // R7
   sw_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl0[B_SW_EN] |=> ($stable(cyc0) && $stable(acc0)));
   // R8
   bad_type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!legal0 && !$rose(ctrl0[B_SW_EN])) |=> $stable(cyc0));
   // R4
   cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl0[B_SW_EN] && legal0 && !$rose(ctrl0[B_SW_EN])) |=>
         cyc0 == CNT_W'($past(cyc0) + 1'b1));
   // R5
   access_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc0 == CNT_W'(rd0 + wr0));

endmodule

bind ddr_traffic_mon ddr_traffic_mon_chk #(
   .ADDR_W  (ADDR_W),
   .CNT_W   (CNT_W),
   .VERSION (VERSION)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_addr   (reg_addr),
   .reg_we     (reg_we),
   .reg_wdata  (reg_wdata),
   .reg_re     (reg_re),
   .reg_rdata  (reg_rdata),
   .reg_rvalid (reg_rvalid),
   .ctrl0      (ctrl_q[0]),
   .rd0        (rd_cnt[0]),
   .wr0        (wr_cnt[0]),
   .cyc0       (cyc_cnt[0]),
   .acc0       (acc_cnt[0])
);

// File: tb/tb_ddr_traffic_mon.sv
module tb_ddr_traffic_mon;

   localparam int          NCH = 2;
   localparam int          CW  = 8;
   localparam int          AW  = 8;
   localparam int          STR = 64;
   localparam logic [31:0] VER = 32'h0000_0031;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] reg_addr;
   logic          reg_we;
   logic [31:0]   reg_wdata;
   logic          reg_re;
   logic [31:0]   reg_rdata;
   logic          reg_rvalid;
   logic [NCH-1:0] cmd_rd;
   logic [NCH-1:0] cmd_wr;

   always #5 clk = ~clk;

   ddr_traffic_mon #(
      .NUM_CH (NCH), .CNT_W (CW), .ADDR_W (AW), .STRIDE (STR),
      .SHARED_CTRL (1'b0), .VERSION (VER)
   ) dut (
      .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_we (reg_we),
      .reg_wdata (reg_wdata), .reg_re (reg_re), .reg_rdata (reg_rdata),
      .reg_rvalid (reg_rvalid), .cmd_rd (cmd_rd), .cmd_wr (cmd_wr)
   );

   int          checks = 0;
   int          errors = 0;
   bit          finished = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] m_exp;
   string       m_tag;

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && reg_rvalid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R11 rvalid without request", 32'd1, 32'd0);
         end else begin
            m_exp = exp_q.pop_front();
            m_tag = tag_q.pop_front();
            check(reg_rdata == m_exp, m_tag, reg_rdata, m_exp);
         end
      end
   end

   task automatic bus_wr(input logic [AW-1:0] a, input logic [15:0] mask,
                         input logic [15:0] data);
      reg_we    = 1'b1;
      reg_addr  = a;
      reg_wdata = {mask, data};
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, input logic [31:0] exp,
                         input string tag);
      reg_re   = 1'b1;
      reg_addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      reg_re   = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R11 watchdog actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; reg_we = 1'b0; reg_re = 1'b0; reg_addr = '0;
      reg_wdata = '0; cmd_rd = '0; cmd_wr = '0;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // reset state
      bus_rd(8'h00, VER, "R1 version after reset");
      bus_rd(8'h04, 32'h0, "R2 ctrl0 reset");
      bus_rd(8'h44, 32'h0, "R3 ctrl1 reset");
      bus_rd(8'h20, 32'h0, "R3 wr0 reset");
      bus_rd(8'h24, 32'h0, "R3 rd0 reset");
      bus_rd(8'h28, 32'h0, "R3 cyc0 reset");
      bus_rd(8'h2C, 32'h0, "R3 acc0 reset");
      idle(1);
      check(reg_rvalid == 1'b0, "R11 rvalid idle", 32'(reg_rvalid), 32'd0);

      // read-only and unmapped
      bus_wr(8'h00, 16'hFFFF, 16'hFFFF);
      bus_rd(8'h00, VER, "R1 version after write");
      bus_wr(8'h24, 16'hFFFF, 16'h00AA);
      bus_rd(8'h24, 32'h0, "R10 counter write ignored");
      bus_rd(8'h10, 32'h0, "R10 unmapped 0x10");
      bus_rd(8'h30, 32'h0, "R10 unmapped 0x30");
      bus_rd(8'h80, 32'h0, "R10 unmapped 0x80");

      // masked control writes
      bus_wr(8'h04, 16'h0010, 16'h01FF);
      bus_rd(8'h04, 32'h10, "R2 single mask bit");
      bus_wr(8'h04, 16'h0000, 16'h01FF);
      bus_rd(8'h04, 32'h10, "R2 zero mask");
      bus_wr(8'h04, 16'h01FF, 16'h0180);
      bus_rd(8'h04, 32'h180, "R2 full field");
      bus_wr(8'h04, 16'hFFFF, 16'hFE00);
      bus_rd(8'h04, 32'h0, "R2 bits above field");

      // bring-up channel 0 with LPDDR4, mixed strobes
      bus_wr(8'h04, 16'h000B, 16'h0000);
      bus_wr(8'h04, 16'h0074, 16'h0010);
      bus_wr(8'h04, 16'h0002, 16'h0002);
      idle(1);
      for (int i = 0; i < 10; i++) begin
         cmd_rd[0] = (i % 2 == 0);
         cmd_wr[0] = (i % 3 == 0);
         cmd_rd[1] = 1'b1;
         cmd_wr[1] = 1'b1;
         @(negedge clk);
      end
      cmd_rd = '0; cmd_wr = '0;
      bus_wr(8'h04, 16'h0002, 16'h0000);
      cmd_rd[0] = 1'b1; cmd_wr[0] = 1'b1;
      idle(5);
      cmd_rd = '0; cmd_wr = '0;
      bus_rd(8'h20, 32'd4,  "R5 wr0 count");
      bus_rd(8'h24, 32'd5,  "R5 rd0 count");
      bus_rd(8'h28, 32'd11, "R4 cyc0 count (R7 hold)");
      bus_rd(8'h2C, 32'd9,  "R5 acc0 coincident strobes");
      bus_rd(8'h64, 32'd0,  "R12 rd1 while ch1 off");
      bus_rd(8'h68, 32'd0,  "R12 cyc1 while ch1 off");

      // restart and illegal type window
      bus_wr(8'h04, 16'h0002, 16'h0002);
      idle(1);
      bus_rd(8'h28, 32'd0, "R6 cyc0 restarted");
      bus_rd(8'h20, 32'd0, "R6 wr0 restarted");
      bus_wr(8'h04, 16'h0020, 16'h0020);
      cmd_rd[0] = 1'b1;
      idle(4);
      cmd_rd = '0;
      bus_rd(8'h24, 32'd0, "R8 rd0 frozen");
      bus_rd(8'h28, 32'd3, "R8 cyc0 frozen");
      bus_rd(8'h2C, 32'd0, "R8 acc0 frozen");
      bus_wr(8'h04, 16'h0020, 16'h0000);
      cmd_rd[0] = 1'b1;
      idle(3);
      cmd_rd = '0;
      bus_wr(8'h04, 16'h0002, 16'h0000);
      bus_rd(8'h24, 32'd3, "R8 rd0 resumed");
      bus_rd(8'h28, 32'd7, "R8 cyc0 resumed without restart");
      bus_rd(8'h2C, 32'd3, "R8 acc0 resumed");

      // wrap on 8-bit counters
      bus_wr(8'h04, 16'h0002, 16'h0002);
      idle(1);
      cmd_wr[0] = 1'b1;
      idle(300);
      cmd_wr = '0;
      bus_wr(8'h04, 16'h0002, 16'h0000);
      bus_rd(8'h20, 32'd44, "R9 wr0 wrapped");
      bus_rd(8'h28, 32'd45, "R9 cyc0 wrapped");
      bus_rd(8'h2C, 32'd44, "R9 acc0 wrapped");
      bus_rd(8'h24, 32'd0,  "R9 rd0 untouched");

      // channel 1 alone, type and enable in one write
      bus_wr(8'h44, 16'h0006, 16'h0006);
      idle(1);
      cmd_rd = '1; cmd_wr = '1;
      idle(5);
      cmd_rd = '0; cmd_wr = '0;
      bus_wr(8'h44, 16'h0002, 16'h0000);
      bus_rd(8'h60, 32'd5,  "R12 wr1");
      bus_rd(8'h64, 32'd5,  "R12 rd1");
      bus_rd(8'h68, 32'd6,  "R12 cyc1");
      bus_rd(8'h6C, 32'd10, "R12 acc1");
      bus_rd(8'h44, 32'h04, "R3 ctrl1 readback");
      bus_rd(8'h20, 32'd44, "R12 wr0 unchanged");

      idle(3);
      check(exp_q.size() == 0, "R11 pending reads", 32'(exp_q.size()), 32'd0);
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule